// File: doc/BRIEF.md
# H-Bridge Gate Control Decoder

This block turns a handful of static configuration bits and two asynchronous control pins into on/off commands for the four switches of an external H-bridge: high and low switch of leg 1 (HS1, LS1) and of leg 2 (HS2, LS2). In full-bridge operation one pin picks the conducting diagonal and the other carries the PWM drive. During the PWM-low phase the bridge freewheels in one of four ways: actively or passively, through either the high or the low switches. In dual half-bridge operation each pin drives one leg on its own.

Two conditions override the pins. A fail-safe input, active low, forces every switch off with an active sink. A cleared output enable forces every switch off with passive discharge. For every switch the block also reports how an off switch is held. Each leg is a small state machine that holds back any turn-on until the opposite switch of that leg has been off for a programmable dead time. Turn-off is never delayed.

The two pins and the fail-safe input pass through a two-stage synchroniser and are treated as 0 while in reset. The decoded request is registered by the leg state machines, so a pin change reaches the outputs on the third rising clock edge. Leg states are LEG_OFF (settled off), LEG_HS_ON, LEG_LS_ON, LEG_GAP_HS (high switch just turned off, dead-time counter running) and LEG_GAP_LS (the same for the low switch). The transitions are:
- LEG_OFF to an ON state when that switch is requested.
- An ON state to its GAP state when the request drops.
- An ON state straight to the opposite ON state when the dead time is 0.
- A GAP state back to its own ON state at once.
- A GAP state to the opposite ON state, or to LEG_OFF, once the counter reaches the dead time.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: While the synchronised fail-safe input is low, all four `gate_on` bits are 0 and all four `sink_off` bits are 1, whatever `out_en` is.
- R2: While fail-safe is high and `out_en` is 0, all four `gate_on` bits are 0 and all four `sink_off` bits are 0 (passive discharge).
- R3: In full-bridge mode (`half_mode`=0) with PWM high, `dir_in2`=0 turns on HS1 and LS2 (`gate_on`=4'b1001), and `dir_in2`=1 turns on HS2 and LS1 (`gate_on`=4'b0110). Bit order of `gate_on` and `sink_off` is [0]=HS1, [1]=LS1, [2]=HS2, [3]=LS2.
- R4: In full-bridge mode with PWM low and `afw_en`=0 (passive freewheel), only one switch stays on. With `fw_high`=0 it is LS2 when dir=0 and LS1 when dir=1. With `fw_high`=1 it is HS1 when dir=0 and HS2 when dir=1.
- R5: In full-bridge mode with PWM low and `afw_en`=1 (active freewheel), both low switches are on when `fw_high`=0 (4'b1010), and both high switches are on when `fw_high`=1 (4'b0101).
- R6: In half-bridge mode (`half_mode`=1), `pwm_in1` high turns on HS1 and low turns on LS1. `dir_in2` drives HS2 and LS2 in the same way.
- R7: While enabled and not in fail-safe, each `sink_off` bit is the inverse of its `gate_on` bit.
- R8: When a leg's request moves from one switch to the other, both switches of that leg are off for exactly `dead_cfg` clock cycles before the new switch turns on.
- R9: A pin change that turns a switch off reaches `gate_on` on the third rising clock edge after the change.
- R10: A switch requested again while its partner has stayed off turns on without any dead-time delay, on the third edge after the pin change.
- R11: HS1 and LS1 are never on together, nor are HS2 and LS2.
- R12: During reset all `gate_on` bits are 0 and all `sink_off` bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_en | input | 1 | Output enable (static configuration) |
| fs_n | input | 1 | Fail-safe, active low, asynchronous |
| half_mode | input | 1 | 0 = full bridge, 1 = dual half-bridge |
| dir_in2 | input | 1 | Direction (full bridge) or leg-2 input (half bridge), asynchronous |
| pwm_in1 | input | 1 | PWM (full bridge) or leg-1 input (half bridge), asynchronous |
| afw_en | input | 1 | 1 = active freewheel, 0 = passive |
| fw_high | input | 1 | Freewheel side: 1 = high switches, 0 = low switches |
| dead_cfg | input | 3 | Dead time in clock cycles |
| gate_on | output | 4 | Switch commands: [0] HS1, [1] LS1, [2] HS2, [3] LS2 |
| sink_off | output | 4 | Per switch: 1 = held off by active sink, 0 = on or passively discharged |

## Verification
The hardest situation to reach from the ports is a request that crosses from one switch of a leg to its partner while the dead-time counter is running. The same stimulus must also tell this apart from a switch being requested again on its own side, which must not wait. The bench reaches the crossing in half-bridge mode by toggling the leg-1 input for every dead-time setting and counting the clock cycles in which both switches are off. It reaches the own-side case in full bridge with passive freewheeling, where one low switch drops out and comes back with the maximum dead time set. An exhaustive sweep over every combination of the control bits, at both extreme dead times, covers the decode table and both kinds of shutdown.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
    localparam int NUM_LEGS = 2;
    localparam int NUM_SW   = 2 * NUM_LEGS;

    typedef enum logic [2:0] {
        LEG_OFF    = 3'd0,
        LEG_HS_ON  = 3'd1,
        LEG_LS_ON  = 3'd2,
        LEG_GAP_HS = 3'd3,
        LEG_GAP_LS = 3'd4
    } leg_state_e;
endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
    parameter int W = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d_async;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/hbg_decode.sv
module hbg_decode (
    input  logic       enable,
    input  logic       half_mode,
    input  logic       dir_s,
    input  logic       pwm_s,
    input  logic       afw_en,
    input  logic       fw_high,
    output logic [3:0] req
);
    // req bit order: [0] HS1, [1] LS1, [2] HS2, [3] LS2
    always_comb begin
        req = 4'b0000;
        if (enable) begin
            if (half_mode) begin
                req[0] = pwm_s;
                req[1] = !pwm_s;
                req[2] = dir_s;
                req[3] = !dir_s;
            end else if (pwm_s) begin
                if (dir_s) req = 4'b0110;
                else       req = 4'b1001;
            end else if (afw_en) begin
                if (fw_high) req = 4'b0101;
                else         req = 4'b1010;
            end else begin
                unique case ({dir_s, fw_high})
                    2'b00:   req = 4'b1000;
                    2'b01:   req = 4'b0001;
                    2'b10:   req = 4'b0010;
                    default: req = 4'b0100;
                endcase
            end
        end
    end
endmodule

// File: rtl/hbg_leg.sv
module hbg_leg
    import hbg_pkg::*;
#(
    parameter int DT_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_hs,
    input  logic            req_ls,
    input  logic [DT_W-1:0] dead_cfg,
    output logic            hs_on,
    output logic            ls_on
);
    localparam logic [DT_W-1:0] CNT_MAX = '1;
    localparam logic [DT_W-1:0] CNT_ONE = DT_W'(1);

    leg_state_e      state, state_nxt;
    logic [DT_W-1:0] cnt, cnt_nxt;
    logic            gap_done;
    logic [DT_W-1:0] cnt_inc;

    assign gap_done = (cnt >= dead_cfg);
    assign cnt_inc  = (cnt == CNT_MAX) ? CNT_MAX : cnt + CNT_ONE;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LEG_OFF;
            cnt   <= CNT_MAX;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            LEG_OFF: begin
                cnt_nxt = CNT_MAX;
                if (req_hs)      state_nxt = LEG_HS_ON;
                else if (req_ls) state_nxt = LEG_LS_ON;
            end
            LEG_HS_ON: begin
                if (!req_hs) begin
                    if (req_ls && dead_cfg == '0) begin
                        state_nxt = LEG_LS_ON;
                    end else begin
                        state_nxt = LEG_GAP_HS;
                        cnt_nxt   = CNT_ONE;
                    end
                end
            end
            LEG_LS_ON: begin
                if (!req_ls) begin
                    if (req_hs && dead_cfg == '0) begin
                        state_nxt = LEG_HS_ON;
                    end else begin
                        state_nxt = LEG_GAP_LS;
                        cnt_nxt   = CNT_ONE;
                    end
                end
            end
            LEG_GAP_HS: begin
                if (req_hs) begin
                    state_nxt = LEG_HS_ON;
                end else if (gap_done) begin
                    state_nxt = req_ls ? LEG_LS_ON : LEG_OFF;
                    cnt_nxt   = CNT_MAX;
                end else begin
                    cnt_nxt = cnt_inc;
                end
            end
            LEG_GAP_LS: begin
                if (req_ls) begin
                    state_nxt = LEG_LS_ON;
                end else if (gap_done) begin
                    state_nxt = req_hs ? LEG_HS_ON : LEG_OFF;
                    cnt_nxt   = CNT_MAX;
                end else begin
                    cnt_nxt = cnt_inc;
                end
            end
            default: begin
                state_nxt = LEG_OFF;
                cnt_nxt   = CNT_MAX;
            end
        endcase
    end

    // outputs
    always_comb begin
        hs_on = (state == LEG_HS_ON);
        ls_on = (state == LEG_LS_ON);
    end
endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
    import hbg_pkg::*;
#(
    parameter int DT_W = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            out_en,
    input  logic            fs_n,
    input  logic            half_mode,
    input  logic            dir_in2,
    input  logic            pwm_in1,
    input  logic            afw_en,
    input  logic            fw_high,
    input  logic [DT_W-1:0] dead_cfg,
    output logic [3:0]      gate_on,
    output logic [3:0]      sink_off
);
    logic [2:0]        pins_s;
    logic              fs_s, dir_s, pwm_s;
    logic [NUM_SW-1:0] req;
    logic              passive_q;

    hbg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({fs_n, dir_in2, pwm_in1}),
        .q_sync  (pins_s)
    );

    assign fs_s  = pins_s[2];
    assign dir_s = pins_s[1];
    assign pwm_s = pins_s[0];

    hbg_decode u_dec (
        .enable    (fs_s && out_en),
        .half_mode (half_mode),
        .dir_s     (dir_s),
        .pwm_s     (pwm_s),
        .afw_en    (afw_en),
        .fw_high   (fw_high),
        .req       (req)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        hbg_leg #(.DT_W(DT_W)) u_leg (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_hs   (req[2*g]),
            .req_ls   (req[2*g+1]),
            .dead_cfg (dead_cfg),
            .hs_on    (gate_on[2*g]),
            .ls_on    (gate_on[2*g+1])
        );
    end

    // shutoff kind follows the same edge as the leg state machines
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) passive_q <= 1'b0;
        else        passive_q <= fs_s && !out_en;
    end

    assign sink_off = ~gate_on & ~{NUM_SW{passive_q}};
endmodule

// File: rtl/hbg_checker.sv
module hbg_checker #(
    parameter int DT_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            out_en,
    input  logic [DT_W-1:0] dead_cfg,
    input  logic            fs_s,
    input  logic [3:0]      req,
    input  logic [3:0]      gate_on,
    input  logic [3:0]      sink_off
);
    a_r1_failsafe_sink: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_s |=> (gate_on == 4'b0000 && sink_off == 4'b1111));

    a_r2_disable_passive: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_s && !out_en) |=> (gate_on == 4'b0000 && sink_off == 4'b0000));

    a_r7_sink_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_s && out_en) |=> (sink_off == ~gate_on));

    a_r11_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_on[0] && gate_on[1]) && !(gate_on[2] && gate_on[3]));

    for (genvar s = 0; s < 4; s++) begin : g_sw
        localparam int PARTNER = s ^ 1;
        logic [DT_W-1:0] partner_off;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                partner_off <= '1;
            else if (gate_on[PARTNER]) partner_off <= '0;
            else if (partner_off != '1) partner_off <= partner_off + 1'b1;
        end

        a_r9_turnoff_now: assert property (@(posedge clk) disable iff (!rst_n)
            !req[s] |=> !gate_on[s]);

        a_r8_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_on[s]) |-> (partner_off >= dead_cfg));
    end
endmodule

bind hbridge_gate_ctrl hbg_checker #(.DT_W(DT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_en   (out_en),
    .dead_cfg (dead_cfg),
    .fs_s     (fs_s),
    .req      (req),
    .gate_on  (gate_on),
    .sink_off (sink_off)
);

// File: tb/hbridge_gate_ctrl_tb.sv
`timescale 1ns/1ps
module hbridge_gate_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       out_en = 1'b0, fs_n = 1'b0, half_mode = 1'b0;
    logic       dir_in2 = 1'b0, pwm_in1 = 1'b0, afw_en = 1'b0, fw_high = 1'b0;
    logic [2:0] dead_cfg = 3'd0;
    logic [3:0] gate_on, sink_off;
    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    hbridge_gate_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .out_en(out_en), .fs_n(fs_n),
        .half_mode(half_mode), .dir_in2(dir_in2), .pwm_in1(pwm_in1),
        .afw_en(afw_en), .fw_high(fw_high), .dead_cfg(dead_cfg),
        .gate_on(gate_on), .sink_off(sink_off)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] model_gates(logic en, logic fs, logic hm,
                                               logic d, logic p, logic a, logic h);
        if (!fs || !en) return 4'b0000;
        if (hm) return {!d, d, !p, p};
        if (p) return d ? 4'b0110 : 4'b1001;
        if (a) return h ? 4'b0101 : 4'b1010;
        if (h) return d ? 4'b0100 : 4'b0001;
        return d ? 4'b0010 : 4'b1000;
    endfunction

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #1000000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait_neg(3);
        chk("R12 gate_on in reset", gate_on, 4'b0000);
        chk("R12 sink_off in reset", sink_off, 4'b1111);
        rst_n = 1'b1;

        // exhaustive sweep of control bits at both extreme dead times
        for (int c = 0; c < 256; c++) begin
            logic [3:0] eg, es;
            string tag;
            @(negedge clk);
            out_en = c[0]; fs_n = c[1]; half_mode = c[2]; dir_in2 = c[3];
            pwm_in1 = c[4]; afw_en = c[5]; fw_high = c[6];
            dead_cfg = c[7] ? 3'd7 : 3'd0;
            wait_neg(14);
            eg = model_gates(c[0], c[1], c[2], c[3], c[4], c[5], c[6]);
            if (!c[1])      es = 4'b1111;
            else if (!c[0]) es = 4'b0000;
            else            es = ~eg;
            if (!c[1])      tag = "R1";
            else if (!c[0]) tag = "R2";
            else if (c[2])  tag = "R6";
            else if (c[4])  tag = "R3";
            else if (c[5])  tag = "R5";
            else            tag = "R4";
            chk({tag, " gate_on"}, gate_on, eg);
            chk({tag, " R7 sink_off"}, sink_off, es);
            chk("R11 leg exclusion",
                {2'b00, gate_on[2] & gate_on[3], gate_on[0] & gate_on[1]}, 4'b0000);
        end

        // dead-time gap per setting, half-bridge leg 1
        for (int d = 0; d < 8; d++) begin
            int gap;
            @(negedge clk);
            out_en = 1; fs_n = 1; half_mode = 1; dir_in2 = 1; pwm_in1 = 1;
            dead_cfg = 3'(d);
            wait_neg(20);
            pwm_in1 = 0;
            gap = 0;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (gate_on[1]) break;
                if (gate_on[1:0] == 2'b00) gap++;
            end
            chk($sformatf("R8 gap cycles dead=%0d", d), 4'(gap), 4'(d));
        end

        // turn-off latency: LS1 on, IN1 rises
        @(negedge clk);
        dead_cfg = 3'd4;
        wait_neg(20);
        pwm_in1 = 1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R9 LS1 still on after two edges", {3'b000, gate_on[1]}, 4'b0001);
        @(negedge clk);
        chk("R9 LS1 off on third edge", {3'b000, gate_on[1]}, 4'b0000);

        // own-side return without dead time: full bridge, passive high freewheel
        @(negedge clk);
        half_mode = 0; dir_in2 = 0; afw_en = 0; fw_high = 1; dead_cfg = 3'd7;
        pwm_in1 = 1;
        wait_neg(20);
        chk("R3 drive before freewheel", gate_on, 4'b1001);
        pwm_in1 = 0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R9 LS2 on before third edge", gate_on, 4'b1001);
        @(negedge clk);
        chk("R4 freewheel high side", gate_on, 4'b0001);
        pwm_in1 = 1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R10 LS2 still off after two edges", gate_on, 4'b0001);
        @(negedge clk);
        chk("R10 LS2 back on third edge", gate_on, 4'b1001);

        // fail-safe overrides a running bridge
        fs_n = 0;
        wait_neg(4);
        chk("R1 gate_on under fail-safe", gate_on, 4'b0000);
        chk("R1 sink_off under fail-safe", sink_off, 4'b1111);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule